// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is the master side of a single-wire, open-drain bus. A host reaches it through a small register port with address, write data, read data and separate write and read strobes. The host starts bus operations by writing command bits. A command bit reads back as 1 while its operation runs and clears itself when the operation ends. There are three single operations. The first is a reset pulse that also checks whether a slave answered with a presence pulse. The second is a slot that writes a 0. The third is a slot that writes a 1 and, in the same slot, reads the bus level.

A write to the data register sends one byte as eight bit slots, least significant bit first. The bus level sampled in each slot is gathered into a received byte in the same order, so writing 0xFF reads one byte from the slave. A status register carries four flags for this byte path.

A programmable divider turns the system clock into a microsecond tick, and every pulse and sampling point is counted in these ticks. The block pulls the wire low through `bus_drive_low`, which drives the enable of an external open-drain pad. It reads the wire level through `bus_in`, which passes through a small synchronizer inside the block.

Top module: `owm_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x0000, the status register (address 1) reads 0x000C, the divider register (address 3) reads 0 and `bus_drive_low` is 0.
- R2: Writing control bit 7 starts a reset sequence, and bit 7 reads 1 until the sequence ends. The sequence drives the bus low for 480 ticks and lasts 960 ticks in total. Control bit 6 is then 1 exactly when the bus was low 70 ticks after the release.
- R3: Writing control bit 5 starts a write-0 slot. The slot drives the bus low for 60 ticks, and bit 5 reads 1 until the slot ends.
- R4: Writing control bit 4 starts a write-1/read slot. The slot drives the bus low for 6 ticks and bit 4 reads 1 until the slot ends. Control bit 3 then holds the bus level sampled 15 ticks into that slot.
- R5: One tick lasts (divider + 1) clock cycles, counted from the start of each slot. The divider register is bits 7:0 of address 3.
- R6: Writing byte B to the data register (address 2) sends eight slots, bit 0 first. A slot for a 0 bit is a 60-tick low and a slot for a 1 bit is a 6-tick low.
- R7: Bits 7:0 of the data register return the byte assembled from the eight slot samples, with the first slot in bit 0. Writing 0xFF therefore reads the byte the slave sends, and writing any other byte reads back that same byte when no slave pulls the bus.
- R8: The status flags are: bit 2 transmit empty, bit 3 shift empty, bit 4 receive full and bit 5 receive shift full. A data write clears bits 2, 3 and 5 while the byte is being sent. When the eighth slot ends, all four flags are set, so the status register reads 0x003C.
- R9: A read of the data register clears status bit 4 and leaves the other flags unchanged.
- R10: Any write to the control, data or divider register is ignored while an operation is running.
- R11: When one control write sets several command bits, only one operation starts. The reset sequence comes first, then the write-0 slot, then the write-1/read slot.
- R12: Each slot lasts 70 ticks, which includes a 10-tick release for recovery. Within a byte, the next slot starts one clock cycle after the previous one ends, so slot starts are 70·(divider+1)+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 divider |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe; reg_rdata is valid on the next cycle |
| reg_rdata | output | 16 | Registered read data |
| bus_drive_low | output | 1 | 1 pulls the wire low through the open-drain pad |
| bus_in | input | 1 | Wire level seen at the pad |

## Verification
The hardest situation to reach is the read path inside byte mode. There, the bit the slave returns has to change from one slot to the next, and it has to be stable at the sampling point 15 ticks into each slot. The bench models the slave on the wire. When a new low pulse starts, the model pulls the line for the next bit of a chosen pattern and holds that level through the sampling point. This lets a sweep of patterns prove that the received byte is assembled least significant bit first. In write mode the same wire model leaves the bus free, so the received byte must equal the byte that was sent. This checks the sampling point against the end of the 60-tick write-0 low and against the 6-tick write-1 low.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] A_DIV  = 2'd3;

  // control register bit positions
  localparam int CB_RST   = 7;
  localparam int CB_PRES  = 6;
  localparam int CB_W0    = 5;
  localparam int CB_W1    = 4;
  localparam int CB_RDBIT = 3;

  // status register bit positions
  localparam int SB_TBE  = 2;
  localparam int SB_TSRE = 3;
  localparam int SB_RBF  = 4;
  localparam int SB_RSRF = 5;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_RST  = 3'd1,
    OP_BIT0 = 3'd2,
    OP_BIT1 = 3'd3,
    OP_BYTE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SLOT_RST = 2'd0,
    SLOT_W0  = 2'd1,
    SLOT_W1  = 2'd2
  } slot_e;
endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt >= div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = !restart && (cnt >= div);
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_none
      assign q = d;
    end else if (STAGES == 1) begin : g_one
      logic s;
      always_ff @(posedge clk) begin
        if (rst) s <= 1'b1;
        else     s <= d;
      end
      assign q = s;
    end else begin : g_many
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/owm_slot.sv
module owm_slot
  import owm_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int RST_LOW    = 480,
  parameter int RST_SAMPLE = 550,
  parameter int RST_TOTAL  = 960,
  parameter int W0_LOW     = 60,
  parameter int W1_LOW     = 6,
  parameter int RD_SAMPLE  = 15,
  parameter int SLOT_TOTAL = 70
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  slot_e kind,
  input  logic  tick,
  input  logic  line,
  output logic  drive_low,
  output logic  busy,
  output logic  done,
  output logic  sample
);
  slot_e            kind_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] samp_at;
  logic [CNT_W-1:0] total;

  always_comb begin
    case (kind_q)
      SLOT_RST: begin
        low_len = CNT_W'(RST_LOW);
        samp_at = CNT_W'(RST_SAMPLE);
        total   = CNT_W'(RST_TOTAL);
      end
      SLOT_W0: begin
        low_len = CNT_W'(W0_LOW);
        samp_at = CNT_W'(RD_SAMPLE);
        total   = CNT_W'(SLOT_TOTAL);
      end
      default: begin
        low_len = CNT_W'(W1_LOW);
        samp_at = CNT_W'(RD_SAMPLE);
        total   = CNT_W'(SLOT_TOTAL);
      end
    endcase
  end

  assign cnt_nx = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= SLOT_W1;
      cnt       <= '0;
      busy      <= 1'b0;
      drive_low <= 1'b0;
      done      <= 1'b0;
      sample    <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        kind_q    <= kind;
        cnt       <= '0;
        busy      <= 1'b1;
        drive_low <= 1'b1;
      end else if (busy && tick) begin
        cnt       <= cnt_nx;
        drive_low <= (cnt_nx < low_len);
        if (cnt_nx == samp_at) sample <= line;
        if (cnt_nx == total) begin
          busy      <= 1'b0;
          drive_low <= 1'b0;
          done      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int DIV_W        = 8,
  parameter int DIV_RESET    = 0,
  parameter int SYNC_STAGES  = 2,
  parameter int BYTE_BITS    = 8,
  parameter int RST_LOW      = 480,
  parameter int RST_RELEASE  = 480,
  parameter int RST_SAMPLE   = 70,
  parameter int W0_LOW       = 60,
  parameter int W1_LOW       = 6,
  parameter int RD_SAMPLE    = 15,
  parameter int SLOT_LEN     = 60,
  parameter int RECOVERY     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              bus_drive_low,
  input  logic              bus_in
);
  localparam int RST_TOTAL  = RST_LOW + RST_RELEASE;
  localparam int RST_SAMP   = RST_LOW + RST_SAMPLE;
  localparam int SLOT_TOTAL = SLOT_LEN + RECOVERY;
  localparam int CNT_W      = $clog2(RST_TOTAL + 1);
  localparam int BIDX_W     = $clog2(BYTE_BITS);

  op_e                  op_q;
  logic [DIV_W-1:0]     div_q;
  logic [BYTE_BITS-1:0] tx_q;
  logic [BYTE_BITS-1:0] rx_q;
  logic [BYTE_BITS-1:0] rx_buf;
  logic [BIDX_W-1:0]    bit_idx;
  logic                 presence_q;
  logic                 rdbit_q;
  logic                 tbe_q, tsre_q, rbf_q, rsrf_q;

  logic  wr_ctrl, wr_data, wr_div, rd_data, idle;
  logic  cmd_rst, cmd_w0, cmd_w1;
  logic  launch_single, launch_byte, next_bit;
  logic  slot_start;
  slot_e slot_kind;
  logic  tick, line_s;
  logic  slot_busy, slot_done, slot_sample, slot_low;
  logic  last_bit;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_data = reg_we && (reg_addr == A_DATA);
  assign wr_div  = reg_we && (reg_addr == A_DIV);
  assign rd_data = reg_re && (reg_addr == A_DATA);
  assign idle    = (op_q == OP_IDLE);

  assign cmd_rst = reg_wdata[CB_RST];
  assign cmd_w0  = reg_wdata[CB_W0];
  assign cmd_w1  = reg_wdata[CB_W1];

  assign launch_single = idle && wr_ctrl && (cmd_rst || cmd_w0 || cmd_w1);
  assign launch_byte   = idle && wr_data;
  assign last_bit      = (bit_idx == BIDX_W'(BYTE_BITS - 1));
  assign next_bit      = (op_q == OP_BYTE) && slot_done && !last_bit;
  assign slot_start    = launch_single || launch_byte || next_bit;

  always_comb begin
    slot_kind = SLOT_W1;
    if (launch_single) begin
      if (cmd_rst)     slot_kind = SLOT_RST;
      else if (cmd_w0) slot_kind = SLOT_W0;
      else             slot_kind = SLOT_W1;
    end else if (launch_byte) begin
      slot_kind = reg_wdata[0] ? SLOT_W1 : SLOT_W0;
    end else if (next_bit) begin
      slot_kind = tx_q[1] ? SLOT_W1 : SLOT_W0;
    end
  end

  owm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .div     (div_q),
    .restart (slot_start),
    .tick    (tick)
  );

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_in),
    .q   (line_s)
  );

  owm_slot #(
    .CNT_W      (CNT_W),
    .RST_LOW    (RST_LOW),
    .RST_SAMPLE (RST_SAMP),
    .RST_TOTAL  (RST_TOTAL),
    .W0_LOW     (W0_LOW),
    .W1_LOW     (W1_LOW),
    .RD_SAMPLE  (RD_SAMPLE),
    .SLOT_TOTAL (SLOT_TOTAL)
  ) u_slot (
    .clk       (clk),
    .rst       (rst),
    .start     (slot_start),
    .kind      (slot_kind),
    .tick      (tick),
    .line      (line_s),
    .drive_low (slot_low),
    .busy      (slot_busy),
    .done      (slot_done),
    .sample    (slot_sample)
  );

  assign bus_drive_low = slot_low;

  // operation sequencing and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q       <= OP_IDLE;
      div_q      <= DIV_W'(DIV_RESET);
      tx_q       <= '0;
      rx_q       <= '0;
      rx_buf     <= '0;
      bit_idx    <= '0;
      presence_q <= 1'b0;
      rdbit_q    <= 1'b0;
      tbe_q      <= 1'b1;
      tsre_q     <= 1'b1;
      rbf_q      <= 1'b0;
      rsrf_q     <= 1'b0;
    end else begin
      if (rd_data) rbf_q <= 1'b0;
      if (wr_div && idle) div_q <= reg_wdata[DIV_W-1:0];

      if (launch_single) begin
        if (cmd_rst)     op_q <= OP_RST;
        else if (cmd_w0) op_q <= OP_BIT0;
        else             op_q <= OP_BIT1;
      end

      if (launch_byte) begin
        op_q    <= OP_BYTE;
        tx_q    <= reg_wdata[BYTE_BITS-1:0];
        bit_idx <= '0;
        tbe_q   <= 1'b0;
        tsre_q  <= 1'b0;
        rsrf_q  <= 1'b0;
      end

      if (slot_done) begin
        case (op_q)
          OP_RST: begin
            presence_q <= !slot_sample;
            op_q       <= OP_IDLE;
          end
          OP_BIT0: begin
            op_q <= OP_IDLE;
          end
          OP_BIT1: begin
            rdbit_q <= slot_sample;
            op_q    <= OP_IDLE;
          end
          OP_BYTE: begin
            rx_q <= {slot_sample, rx_q[BYTE_BITS-1:1]};
            tx_q <= tx_q >> 1;
            if (last_bit) begin
              rx_buf <= {slot_sample, rx_q[BYTE_BITS-1:1]};
              op_q   <= OP_IDLE;
              tbe_q  <= 1'b1;
              tsre_q <= 1'b1;
              rbf_q  <= 1'b1;
              rsrf_q <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
          default: op_q <= OP_IDLE;
        endcase
      end
    end
  end

  // read path
  logic [DATA_W-1:0] ctrl_word, stat_word, data_word, div_word;

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CB_RST]   = (op_q == OP_RST);
    ctrl_word[CB_PRES]  = presence_q;
    ctrl_word[CB_W0]    = (op_q == OP_BIT0);
    ctrl_word[CB_W1]    = (op_q == OP_BIT1);
    ctrl_word[CB_RDBIT] = rdbit_q;

    stat_word          = '0;
    stat_word[SB_TBE]  = tbe_q;
    stat_word[SB_TSRE] = tsre_q;
    stat_word[SB_RBF]  = rbf_q;
    stat_word[SB_RSRF] = rsrf_q;

    data_word                  = '0;
    data_word[BYTE_BITS-1:0]   = rx_buf;
    div_word                   = '0;
    div_word[DIV_W-1:0]        = div_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_word;
        A_STAT:  reg_rdata <= stat_word;
        A_DATA:  reg_rdata <= data_word;
        default: reg_rdata <= div_word;
      endcase
    end
  end
endmodule

// File: rtl/owm_ctrl_chk.sv
module owm_ctrl_chk
  import owm_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int RST_LOW = 480
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic              reg_re,
  input logic              bus_drive_low,
  input op_e               op_q,
  input logic              slot_busy,
  input logic              slot_done,
  input logic              tbe_q,
  input logic              tsre_q,
  input logic              rbf_q,
  input logic [DIV_W-1:0]  div_q
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst)                low_run <= 0;
    else if (bus_drive_low) low_run <= low_run + 1;
    else                    low_run <= 0;
  end

  // R3: no pull on the wire unless an operation is running
  p_idle_released_r3: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_IDLE) |-> !bus_drive_low);

  // R2: no low pulse is longer than the reset pulse
  p_low_window_r2: assert property (@(posedge clk) disable iff (rst)
    low_run <= RST_LOW * (int'(div_q) + 1));

  // R8: transmit flags stay low while a byte is in flight
  p_byte_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_BYTE) |-> (!tbe_q && !tsre_q));

  // R10: a write during a running slot does not change the operation
  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (slot_busy && reg_we) |=> $stable(op_q));

  // R9: reading the data register clears receive-full
  p_rbf_read_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr == A_DATA && !slot_done) |=> !rbf_q);

  // R12: a slot only completes when no operation is idle
  p_done_has_op_r12: assert property (@(posedge clk) disable iff (rst)
    slot_done |-> (op_q != OP_IDLE));
endmodule

bind owm_ctrl owm_ctrl_chk #(.DIV_W(DIV_W), .RST_LOW(RST_LOW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_addr      (reg_addr),
  .reg_we        (reg_we),
  .reg_re        (reg_re),
  .bus_drive_low (bus_drive_low),
  .op_q          (op_q),
  .slot_busy     (slot_busy),
  .slot_done     (slot_done),
  .tbe_q         (tbe_q),
  .tsre_q        (tsre_q),
  .rbf_q         (rbf_q),
  .div_q         (div_q)
);

// File: tb/owm_ctrl_test.sv
module owm_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [15:0] reg_rdata;
  logic        bus_drive_low;
  logic        slave_low = 1'b0;
  logic        bus_in;

  assign bus_in = ~(bus_drive_low | slave_low);

  owm_ctrl uut (
    .clk           (clk),
    .rst           (rst),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_we        (reg_we),
    .reg_re        (reg_re),
    .reg_rdata     (reg_rdata),
    .bus_drive_low (bus_drive_low),
    .bus_in        (bus_in)
  );

  always #2 clk = ~clk;

  int vecs = 0;
  int bad  = 0;
  bit finished = 0;

  // wire monitor and slave model
  int   cyc = 0;
  int   np = 0;
  int   pw [0:15];
  int   ps [0:15];
  logic prev_low = 1'b0;
  bit   rd_mode = 0;
  logic [7:0] rd_pat = '0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bus_drive_low && !prev_low) begin
      ps[np] = cyc;
      if (rd_mode) slave_low = !rd_pat[np[2:0]];
    end
    if (!bus_drive_low && prev_low && np < 16) begin
      pw[np] = cyc - ps[np];
      np = np + 1;
    end
    prev_low = bus_drive_low;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_ctrl_idle();
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, v);
      if ((v & 16'h00B0) == 0) break;
    end
  endtask

  task automatic wait_byte_done();
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd1, v);
      if (v[3]) break;
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    np = 0;
  endtask

  // one byte transfer with full checking
  task automatic do_byte(input logic [7:0] tx, input bit rmode,
                         input logic [7:0] pat, input int d);
    logic [15:0] v;
    logic [7:0]  exp_rx;
    int          ok_w, ok_s;
    rd_mode = rmode;
    rd_pat  = pat;
    slave_low = 1'b0;
    clear_mon();
    wr(2'd2, {8'h00, tx});
    rd(2'd1, v);
    check((v & 16'h002C) == 0, "R8 flags cleared during byte", v, 0);
    wait_byte_done();
    repeat (2) @(negedge clk);
    check(np == 8, "R6 eight slots", np, 8);
    ok_w = 1; ok_s = 1;
    for (int b = 0; b < 8; b++) begin
      if (pw[b] != (tx[b] ? 6 : 60) * (d + 1)) ok_w = 0;
      if (b > 0 && (ps[b] - ps[b-1]) != 70 * (d + 1) + 1) ok_s = 0;
    end
    check(ok_w == 1, "R6 slot low widths", tx, tx);
    check(ok_s == 1, "R12 slot spacing", ps[1] - ps[0], 70 * (d + 1) + 1);
    rd(2'd1, v);
    check(v == 16'h003C, "R8 flags after byte", v, 16'h003C);
    exp_rx = rmode ? pat : tx;
    rd(2'd2, v);
    check(v == {8'h00, exp_rx}, "R7 received byte", v, exp_rx);
    rd(2'd1, v);
    check(v == 16'h002C, "R9 receive full cleared", v, 16'h002C);
    rd_mode = 0;
    slave_low = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check(v == 16'h0000, "R1 control after reset", v, 0);
    rd(2'd1, v); check(v == 16'h000C, "R1 status after reset", v, 16'h000C);
    rd(2'd3, v); check(v == 16'h0000, "R1 divider after reset", v, 0);
    check(bus_drive_low == 1'b0, "R1 bus released", bus_drive_low, 0);

    // R2 reset with presence
    slave_low = 1'b1;
    clear_mon();
    wr(2'd0, 16'h0080);
    rd(2'd0, v); check(v[7] == 1'b1, "R2 reset bit busy", v, 16'h0080);
    wait_ctrl_idle();
    check(np == 1 && pw[0] == 480, "R2 reset low width", pw[0], 480);
    rd(2'd0, v); check(v == 16'h0040, "R2 presence seen", v, 16'h0040);
    slave_low = 1'b0;

    // R2 reset without presence
    wr(2'd0, 16'h0080);
    wait_ctrl_idle();
    rd(2'd0, v); check(v == 16'h0000, "R2 no presence", v, 0);

    // R3 write-0 slot
    clear_mon();
    wr(2'd0, 16'h0020);
    rd(2'd0, v); check(v[5] == 1'b1, "R3 write-0 busy", v, 16'h0020);
    wait_ctrl_idle();
    check(np == 1 && pw[0] == 60, "R3 write-0 low width", pw[0], 60);
    rd(2'd0, v); check(v == 16'h0000, "R3 write-0 self-clear", v, 0);

    // R4 write-1/read slot, slave holds 0 then releases
    slave_low = 1'b1;
    clear_mon();
    wr(2'd0, 16'h0010);
    rd(2'd0, v); check(v[4] == 1'b1, "R4 read slot busy", v, 16'h0010);
    wait_ctrl_idle();
    rd(2'd0, v); check(v == 16'h0000, "R4 sampled 0", v, 0);
    slave_low = 1'b0;
    clear_mon();
    wr(2'd0, 16'h0010);
    wait_ctrl_idle();
    check(np == 1 && pw[0] == 6, "R4 write-1 low width", pw[0], 6);
    rd(2'd0, v); check(v == 16'h0008, "R4 sampled 1", v, 16'h0008);

    // R10 writes ignored while busy
    clear_mon();
    wr(2'd0, 16'h0020);
    wr(2'd0, 16'h0080);
    wr(2'd2, 16'h0055);
    wr(2'd3, 16'h0005);
    wait_ctrl_idle();
    repeat (300) @(negedge clk);
    check(np == 1 && pw[0] == 60, "R10 only first slot ran", np, 1);
    rd(2'd1, v); check(v == 16'h000C, "R10 data write ignored", v, 16'h000C);
    rd(2'd3, v); check(v == 16'h0000, "R10 divider write ignored", v, 0);

    // R11 priority
    clear_mon();
    wr(2'd0, 16'h00B0);
    wait_ctrl_idle();
    check(np == 1 && pw[0] == 480, "R11 reset wins", pw[0], 480);
    clear_mon();
    wr(2'd0, 16'h0030);
    wait_ctrl_idle();
    check(np == 1 && pw[0] == 60, "R11 write-0 beats write-1", pw[0], 60);

    // R6 R7 R8 R9 R12 byte write sweep
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + 5) % 256);
      if (b == 8'hFF) b = 8'hFE;
      do_byte(b, 1'b0, 8'h00, 0);
    end
    // R7 byte read sweep with slave patterns
    for (int i = 0; i < 40; i++) begin
      logic [7:0] p;
      p = 8'((i * 73 + 11) % 256);
      do_byte(8'hFF, 1'b1, p, 0);
    end

    // R5 divider scaling
    wr(2'd3, 16'h0003);
    rd(2'd3, v); check(v == 16'h0003, "R5 divider readback", v, 3);
    clear_mon();
    wr(2'd0, 16'h0020);
    wait_ctrl_idle();
    check(pw[0] == 240, "R5 write-0 at divider 3", pw[0], 240);
    clear_mon();
    wr(2'd0, 16'h0010);
    wait_ctrl_idle();
    check(pw[0] == 24, "R5 write-1 at divider 3", pw[0], 24);
    do_byte(8'hA5, 1'b0, 8'h00, 3);
    do_byte(8'hFF, 1'b1, 8'h3C, 3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule